// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the running memory address and the remaining transfer count for a single DMA channel. Before a transfer, the controller presents an 8-bit page, a 16-bit start offset, a 16-bit count and a channel width. It then pulses the load strobe once. While the transfer runs, every completed bus transfer is signalled by one pulse of the step strobe. The engine moves the offset forward and the count down, and it drives a 24-bit physical address on every cycle.

There are two channel widths. A byte channel forms its address as the page followed by the offset, so one page covers 64 KB. A word channel moves 16-bit words. It shifts the offset left by one bit, ignores the lowest page bit, and covers 128 KB per page. In both widths the offset wraps inside its page and never carries into the page value.

The count is loaded as the number of transfers minus one. The step that moves the count from zero to all-ones is the last transfer. That step raises the terminal-count flag, and the engine then ignores further steps until the next load. After completion the count reads all-ones, so count plus one gives a residue of zero.

Top module: `dma_addr_cnt_engine`

## Requirements
- R1: In byte mode (width input 0 at load), the physical address equals the page in bits 23:16 and the 16-bit offset in bits 15:0.
- R2: In word mode (width input 1 at load), the physical address equals page bits 7:1 in bits 23:17, the offset in bits 16:1, and 0 in bit 0. Page bit 0 has no effect on the address.
- R3: The offset counter wraps from 0xFFFF to 0x0000 without changing the page, in both modes.
- R4: A loaded count N allows exactly N+1 accepted steps before terminal count. A loaded count of 0x0000 completes after one step, and 0xFFFF completes after 65536 steps.
- R5: Each accepted step adds one to the offset and subtracts one from the count. In word mode one step is one 16-bit word, which moves the physical address by 2.
- R6: The terminal-count flag rises on the step that takes the count from 0x0000 to 0xFFFF. From then on the count reads 0xFFFF.
- R7: While the terminal-count flag is high and no load is applied, step pulses change neither the address nor the count.
- R8: A load copies page, offset, count and width into the engine and clears the terminal-count flag. A load applied in the same cycle as a step wins, and the step is dropped.
- R9: After reset the page, offset and count are zero, the flag is low, and the width is byte. Steps are ignored until the first load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load strobe for page, offset, count and width |
| wide_i | input | 1 | Channel width at load: 0 byte, 1 word |
| page_i | input | 8 | Page value to load |
| offset_i | input | 16 | Start offset to load |
| count_i | input | 16 | Transfers minus one, to load |
| step_i | input | 1 | One pulse per completed transfer |
| phys_addr_o | output | 24 | Current physical address |
| count_o | output | 16 | Current remaining count (transfers minus one) |
| tc_o | output | 1 | Terminal count reached |

## Verification
A wrong offset or page register shows up on the physical address in the cycle after the step that corrupted it. The address would move by something other than 1 (byte) or 2 (word), or bits 23:16 would change across an offset wrap. A count register that goes wrong shows at the count port one cycle after the offending step. It shows again at completion, when the flag rises a step early or late and the count does not read 0xFFFF. Keeping a channel armed too long is exposed by the bench steps sent after completion, which must leave every output frozen.

// File: rtl/dma_eng_pkg.sv
// Package: dma_eng_pkg
// Holds the types and the address-forming function shared by the engine.
// Assumes the page is wider than one bit, so a word channel has bits to keep.
package dma_eng_pkg;

    typedef enum logic {
        XFER_BYTE = 1'b0,
        XFER_WORD = 1'b1
    } xfer_width_e;

    // Forms the physical address from page and offset for the given width.
    function automatic logic [23:0] form_phys24(
        input xfer_width_e  width,
        input logic [7:0]   page,
        input logic [15:0]  ofs
    );
        logic [23:0] result;
        if (width == XFER_WORD) begin
            result = {page[7:1], ofs, 1'b0};
        end else begin
            result = {page, ofs};
        end
        return result;
    endfunction

endpackage

// File: rtl/dma_eng_count.sv
// Module: dma_eng_count
// Keeps the remaining transfer count (transfers minus one), the armed state
// and the terminal-count flag. It also issues the accepted-step pulse that
// moves the address counter.
// Assumes: a load takes priority over a step in the same cycle; the engine
// starts disarmed after reset.
module dma_eng_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] count_o,
    output logic             tc_o,
    output logic             adv_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             tc_q;
    logic             last_xfer;

    // Decides whether this cycle's step is accepted.
    always_comb begin
        adv_o     = step_i && armed_q && !load_i;
        last_xfer = (cnt_q == CNT_ZERO);
    end

    // Updates the count, armed state and terminal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= CNT_ZERO;
            armed_q <= 1'b0;
            tc_q    <= 1'b0;
        end else if (load_i) begin
            cnt_q   <= count_i;
            armed_q <= 1'b1;
            tc_q    <= 1'b0;
        end else if (adv_o) begin
            cnt_q <= cnt_q - CNT_ONE;
            if (last_xfer) begin
                armed_q <= 1'b0;
                tc_q    <= 1'b1;
            end
        end
    end

    assign count_o = cnt_q;
    assign tc_o    = tc_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && !last_xfer) |=> (count_o == $past(count_o) - CNT_ONE)); // R5

    AST_TC_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && last_xfer) |=> (tc_o && (&count_o))); // R6

    AST_TC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !load_i) |=> (tc_o && $stable(count_o))); // R7

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!tc_o && count_o == $past(count_i))); // R8

endmodule

// File: rtl/dma_eng_addr.sv
// Module: dma_eng_addr
// Holds the page, the 16-bit offset and the latched channel width. The offset
// advances by one on each accepted step and wraps inside its page.
// Assumes: adv_i is never high in a load cycle (the count module masks it).
module dma_eng_addr #(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              wide_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [OFS_W-1:0]  offset_i,
    input  logic              adv_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [OFS_W-1:0]  ofs_o,
    output logic              wide_o
);

    localparam logic [OFS_W-1:0] OFS_ONE = OFS_W'(1);

    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              wide_q;

    // Captures page and width on load; the page never moves otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            wide_q <= 1'b0;
        end else if (load_i) begin
            page_q <= page_i;
            wide_q <= wide_i;
        end
    end

    // Loads or advances the offset, wrapping at the page edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (load_i) begin
            ofs_q <= offset_i;
        end else if (adv_i) begin
            ofs_q <= ofs_q + OFS_ONE;
        end
    end

    assign page_o = page_q;
    assign ofs_o  = ofs_q;
    assign wide_o = wide_q;

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(page_o) && $stable(wide_o))); // R3

    AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (ofs_o == $past(ofs_o) + OFS_ONE)); // R5

    AST_OFS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(ofs_o)); // R7

endmodule

// File: rtl/dma_eng_map.sv
// Module: dma_eng_map
// Combinational mapping from page and offset to the 24-bit physical address.
// Assumes the default widths (8-bit page, 16-bit offset), which the shared
// function is written for.
module dma_eng_map
    import dma_eng_pkg::*;
(
    input  logic        wide_i,
    input  logic [7:0]  page_i,
    input  logic [15:0] ofs_i,
    output logic [23:0] phys_o
);

    xfer_width_e width;

    // Selects the address layout for the latched width.
    always_comb begin
        width  = wide_i ? XFER_WORD : XFER_BYTE;
        phys_o = form_phys24(width, page_i, ofs_i);
    end

    // Checks that a word address stays even and its high bits are page bits 7:1.
    always_comb begin
        if (wide_i) begin
            AST_WORD_ALIGN: assert (phys_o[0] == 1'b0 && phys_o[23:17] == page_i[7:1]); // R2
        end
    end

endmodule

// File: rtl/dma_addr_cnt_engine.sv
// Module: dma_addr_cnt_engine
// Address and count engine for one DMA channel: address counter, count
// counter with terminal flag, and physical address mapping for byte or word
// channels.
// Assumes: one step pulse per completed transfer; the width is latched on load.
module dma_addr_cnt_engine #(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 16,
    parameter int CNT_W  = 16,
    localparam int PHYS_W = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              wide_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [OFS_W-1:0]  offset_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              step_i,
    output logic [PHYS_W-1:0] phys_addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              tc_o
);

    logic              adv;
    logic [PAGE_W-1:0] page_cur;
    logic [OFS_W-1:0]  ofs_cur;
    logic              wide_cur;

    dma_eng_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .step_i  (step_i),
        .count_i (count_i),
        .count_o (count_o),
        .tc_o    (tc_o),
        .adv_o   (adv)
    );

    dma_eng_addr #(
        .PAGE_W (PAGE_W),
        .OFS_W  (OFS_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .wide_i   (wide_i),
        .page_i   (page_i),
        .offset_i (offset_i),
        .adv_i    (adv),
        .page_o   (page_cur),
        .ofs_o    (ofs_cur),
        .wide_o   (wide_cur)
    );

    dma_eng_map u_map (
        .wide_i (wide_cur),
        .page_i (page_cur),
        .ofs_i  (ofs_cur),
        .phys_o (phys_addr_o)
    );

    AST_STEP_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && !load_i) |=> $stable(phys_addr_o)); // R7

    AST_LOAD_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !tc_o); // R8

endmodule

// File: tb/dma_addr_cnt_engine_tb.sv
`timescale 1ns/1ps
module dma_addr_cnt_engine_tb;

    typedef struct packed {
        logic        wide;
        logic [7:0]  page;
        logic [15:0] ofs;
        logic [15:0] cnt;
        logic [7:0]  steps;
        logic [23:0] exp_addr;
        logic [15:0] exp_cnt;
        logic        exp_tc;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h12, 16'h3400, 16'h0010, 8'd0, 24'h123400, 16'h0010, 1'b0}, // R1 load
        '{1'b0, 8'h12, 16'h3400, 16'h0010, 8'd5, 24'h123405, 16'h000B, 1'b0}, // R5 byte
        '{1'b0, 8'h05, 16'hFFFE, 16'h0009, 8'd3, 24'h050001, 16'h0006, 1'b0}, // R3 byte wrap
        '{1'b1, 8'h13, 16'h2000, 16'h00FF, 8'd0, 24'h124000, 16'h00FF, 1'b0}, // R2 odd page
        '{1'b1, 8'h12, 16'h2000, 16'h00FF, 8'd0, 24'h124000, 16'h00FF, 1'b0}, // R2 even page
        '{1'b1, 8'h40, 16'hFFFF, 16'h0004, 8'd2, 24'h400002, 16'h0002, 1'b0}, // R3 word wrap
        '{1'b1, 8'h40, 16'h8000, 16'h0003, 8'd1, 24'h410002, 16'h0002, 1'b0}, // R5 word step
        '{1'b0, 8'hAB, 16'h0100, 16'h0000, 8'd1, 24'hAB0101, 16'hFFFF, 1'b1}, // R4 single
        '{1'b0, 8'hAB, 16'h0100, 16'h0002, 8'd3, 24'hAB0103, 16'hFFFF, 1'b1}, // R6 end
        '{1'b0, 8'hAB, 16'h0100, 16'h0002, 8'd6, 24'hAB0103, 16'hFFFF, 1'b1}, // R7 extra
        '{1'b0, 8'hFF, 16'hFFFF, 16'h1234, 8'd0, 24'hFFFFFF, 16'h1234, 1'b0}  // R1 top
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [7:0]  page_i = '0;
    logic [15:0] offset_i = '0;
    logic [15:0] count_i = '0;
    logic        step_i = 1'b0;
    logic [23:0] phys_addr_o;
    logic [15:0] count_o;
    logic        tc_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma_addr_cnt_engine u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .wide_i      (wide_i),
        .page_i      (page_i),
        .offset_i    (offset_i),
        .count_i     (count_i),
        .step_i      (step_i),
        .phys_addr_o (phys_addr_o),
        .count_o     (count_o),
        .tc_o        (tc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [23:0] ea,
                             input logic [15:0] ec, input logic et);
        check({req, " addr"}, 32'(phys_addr_o), 32'(ea));
        check({req, " count"}, 32'(count_o), 32'(ec));
        check({req, " tc"}, 32'(tc_o), 32'(et));
    endtask

    task automatic do_load(input logic w, input logic [7:0] p,
                           input logic [15:0] o, input logic [15:0] c);
        @(negedge clk);
        wide_i = w; page_i = p; offset_i = o; count_i = c; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic do_steps(input int n);
        if (n > 0) begin
            step_i = 1'b1;
            repeat (n) @(negedge clk);
            step_i = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 reset", 24'h000000, 16'h0000, 1'b0);

        // R9: steps before any load are ignored
        do_steps(4);
        check_all("R9 no load", 24'h000000, 16'h0000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            do_load(VECS[i].wide, VECS[i].page, VECS[i].ofs, VECS[i].cnt);
            do_steps(int'(VECS[i].steps));
            check_all($sformatf("R1-table vec%0d", i), VECS[i].exp_addr,
                      VECS[i].exp_cnt, VECS[i].exp_tc);
        end

        // R8: load clears tc after completion (table left byte 0xFF/0xFFFF)
        do_load(1'b0, 8'hAB, 16'h0100, 16'h0000);
        do_steps(1);
        check("R6 tc set", 32'(tc_o), 32'd1);
        do_load(1'b0, 8'h01, 16'h0010, 16'h0005);
        check_all("R8 reload", 24'h010010, 16'h0005, 1'b0);

        // R8: load and step in the same cycle, step dropped
        @(negedge clk);
        wide_i = 1'b0; page_i = 8'h22; offset_i = 16'h0040; count_i = 16'h0003;
        load_i = 1'b1; step_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b0;
        check_all("R8 load wins", 24'h220040, 16'h0003, 1'b0);

        // R2: width latched at load; changing wide_i later has no effect
        wide_i = 1'b1;
        @(negedge clk);
        check("R8 width latched", 32'(phys_addr_o), 32'h00220040);

        // R4: full 65536-transfer word run
        do_load(1'b1, 8'h02, 16'h0000, 16'hFFFF);
        do_steps(65535);
        check_all("R4 before last", 24'h03FFFE, 16'h0000, 1'b0);
        do_steps(1);
        check_all("R4 full run", 24'h020000, 16'hFFFF, 1'b1);
        do_steps(2);
        check_all("R7 frozen", 24'h020000, 16'hFFFF, 1'b1);

        // R9: reset in mid transfer returns to the reset state
        do_load(1'b1, 8'h33, 16'h1111, 16'h0022);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 re-reset", 24'h000000, 16'h0000, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule